// File: doc/BRIEF.md
# Switch-Triggered Melody Player

This block turns a bank of slide switches into a small tone source. Seven free-running square-wave dividers give the seven notes of one diatonic octave. With the melody switch off, the lowest-numbered note switch that is on picks the tone. With it on, a sequencer walks a fixed built-in song of timed notes and rests. A short silent gap follows every entry, so two repeated notes of the same pitch sound separate.

The chosen tone bit is sampled at a fast divided rate and shifted into a 12-bit word. An external converter fetches samples by pulsing a chip-select line. Each rising edge of that line is synchronised to the system clock, and the current word is then copied to the parallel music output. All timing constants are parameters: note half-periods, the sampling divider, the beat length and the gap length. The defaults suit a 100 MHz clock with a 250 ms beat and a 20 ms gap.

Top module: `melody_player`

## Requirements
- R1: While rst_ni is low, tone_o and music_o are 0.
- R2: Note k (code k, where 0 is do and 6 is ti) is a square wave that toggles on the first clock edge after reset and then every HALF_WRAP[k]+1 edges. It runs in every mode.
- R3: With melody_en_i low, tone_o follows the note whose switch is on with the lowest index (note_sw_i[0] is do, the highest priority). It is 0 when no switch is on.
- R4: With melody_en_i high, tone_o plays the song, given as (note code or rest, beats): (0,1) (0,1) (1,2) (0,2) (3,2) (2,4) (rest,2) (0,1) (0,1) (1,2) (0,2) (4,2) (3,4) (rest,2). Entry 0 comes first.
- R5: Each entry sounds for beats×BEAT_CYCLES edges and is then followed by GAP_CYCLES edges of silence (tone_o = 0).
- R6: A rest entry keeps tone_o at 0 for its whole length.
- R7: The song starts at entry 0 whenever melody_en_i rises after having been low for at least one edge. After the last entry it loops back to entry 0.
- R8: Lowering melody_en_i returns tone_o to the manual selection in the same cycle, before any clock edge.
- R9: The sampling clock toggles on the first edge after reset and then every SAMPLE_WRAP+1 edges. On each edge where it rises, the sample word shifts left by one and takes the tone_o value present before that edge into bit 0.
- R10: A rise of cs_i passes through a two-stage synchroniser. On the second edge after the rise, music_o loads the sample word as it stood after the first edge. At all other times music_o holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| note_sw_i | input | NUM_NOTES | Manual note switches, bit 0 = do |
| melody_en_i | input | 1 | Plays the song while high |
| cs_i | input | 1 | Asynchronous sample fetch strobe |
| tone_o | output | 1 | Selected tone bit |
| music_o | output | SAMPLE_W | Latched sample word |

## Verification
tone_o is checked every cycle after the edge. Its expected value is rebuilt from the number of edges since reset, for the note periods, and from the number of edges since melody_en_i rose, for the song position. A shift in the sample word lands on the edge where the sampling clock rises, and it uses the tone value from before that edge. The bench therefore computes that value before it advances the clock. music_o is due two edges after a cs_i rise. The bench models the two-stage delay and compares music_o every cycle, so an early, late or spurious load shows up.

// File: rtl/melody_pkg.sv
package melody_pkg;
  localparam int NUM_NOTES = 7;
  localparam int SONG_LEN  = 14;
  localparam int DUR_W     = 4;

  typedef enum logic [2:0] {
    NOTE_DO, NOTE_RE, NOTE_MI, NOTE_FA, NOTE_SO, NOTE_LA, NOTE_TI
  } note_e;

  typedef struct packed {
    logic             rest;
    note_e            note;
    logic [DUR_W-1:0] beats;
  } song_entry_t;

  function automatic song_entry_t mk(logic r, note_e n, int unsigned b);
    return '{rest: r, note: n, beats: DUR_W'(b)};
  endfunction

  function automatic song_entry_t song_at(int unsigned idx);
    case (idx)
      0, 1, 7, 8: return mk(1'b0, NOTE_DO, 1);
      2, 9:       return mk(1'b0, NOTE_RE, 2);
      3, 10:      return mk(1'b0, NOTE_DO, 2);
      4:          return mk(1'b0, NOTE_FA, 2);
      5:          return mk(1'b0, NOTE_MI, 4);
      11:         return mk(1'b0, NOTE_SO, 2);
      12:         return mk(1'b0, NOTE_FA, 4);
      default:    return mk(1'b1, NOTE_DO, 2);
    endcase
  endfunction
endpackage

// File: rtl/note_tone_bank.sv
module note_tone_bank
  import melody_pkg::*;
#(
  parameter int unsigned HALF_WRAP [NUM_NOTES] = '{191112, 170261, 151685, 143172, 127552, 113635, 101238},
  parameter int          CNT_W = 18
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  output logic [NUM_NOTES-1:0] tone_o
);
  for (genvar g = 0; g < NUM_NOTES; g++) begin : g_note
    localparam logic [CNT_W-1:0] WRAP = CNT_W'(HALF_WRAP[g]);
    logic [CNT_W-1:0] cnt_q;
    logic             tone_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        tone_q <= 1'b0;
      end else begin
        cnt_q <= (cnt_q == WRAP) ? '0 : cnt_q + 1'b1;
        if (cnt_q == '0) tone_q <= ~tone_q;
      end
    end
    assign tone_o[g] = tone_q;
  end
endmodule

// File: rtl/sample_shifter.sv
module sample_shifter #(
  parameter int SAMPLE_WRAP = 417,
  parameter int SAMPLE_W    = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tone_i,
  output logic                tick_o,
  output logic [SAMPLE_W-1:0] word_o
);
  localparam int DIV_W = $clog2(SAMPLE_WRAP + 1);
  localparam logic [DIV_W-1:0] WRAP = DIV_W'(SAMPLE_WRAP);

  logic [DIV_W-1:0] div_q;
  logic             sclk_q;

  // rising edge of the divided sampling clock
  assign tick_o = (div_q == '0) && !sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
      word_o <= '0;
    end else begin
      div_q <= (div_q == WRAP) ? '0 : div_q + 1'b1;
      if (div_q == '0) sclk_q <= ~sclk_q;
      if (tick_o) word_o <= {word_o[SAMPLE_W-2:0], tone_i};
    end
  end
endmodule

// File: rtl/song_sequencer.sv
module song_sequencer
  import melody_pkg::*;
#(
  parameter int BEAT_CYCLES = 25_000_000,
  parameter int GAP_CYCLES  = 2_000_000
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  output logic [2:0]                  note_o,
  output logic                        sound_o,
  output logic                        gap_o,
  output logic [$clog2(SONG_LEN)-1:0] idx_o
);
  localparam int IDX_W  = $clog2(SONG_LEN);
  localparam int T_MAX  = (BEAT_CYCLES > GAP_CYCLES) ? BEAT_CYCLES : GAP_CYCLES;
  localparam int TICK_W = $clog2(T_MAX + 1);
  localparam logic [TICK_W-1:0] BEAT_END = TICK_W'(BEAT_CYCLES - 1);
  localparam logic [TICK_W-1:0] GAP_END  = TICK_W'(GAP_CYCLES - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(SONG_LEN - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [TICK_W-1:0] tick_q;
  logic [DUR_W-1:0]  beat_q;
  logic              gap_q;
  song_entry_t       cur;

  assign cur = song_at(32'(idx_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      tick_q <= '0;
      beat_q <= '0;
      gap_q  <= 1'b0;
    end else if (!en_i) begin
      idx_q  <= '0;
      tick_q <= '0;
      beat_q <= '0;
      gap_q  <= 1'b0;
    end else if (gap_q) begin
      if (tick_q == GAP_END) begin
        tick_q <= '0;
        gap_q  <= 1'b0;
        idx_q  <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end else if (tick_q == BEAT_END) begin
      tick_q <= '0;
      if (beat_q == cur.beats - 1'b1) begin
        beat_q <= '0;
        gap_q  <= 1'b1;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  assign note_o  = cur.note;
  assign sound_o = !gap_q && !cur.rest;
  assign gap_o   = gap_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/melody_player.sv
module melody_player
  import melody_pkg::*;
#(
  parameter int unsigned HALF_WRAP [NUM_NOTES] = '{191112, 170261, 151685, 143172, 127552, 113635, 101238},
  parameter int          CNT_W       = 18,
  parameter int          SAMPLE_WRAP = 417,
  parameter int          SAMPLE_W    = 12,
  parameter int          BEAT_CYCLES = 25_000_000,
  parameter int          GAP_CYCLES  = 2_000_000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_NOTES-1:0] note_sw_i,
  input  logic                 melody_en_i,
  input  logic                 cs_i,
  output logic                 tone_o,
  output logic [SAMPLE_W-1:0]  music_o
);
  localparam int IDX_W = $clog2(SONG_LEN);

  logic [NUM_NOTES-1:0] tones;
  logic [7:0]           tone_pad;
  logic [2:0]           seq_note;
  logic                 seq_sound, seq_gap;
  logic [IDX_W-1:0]     seq_idx;
  logic                 man_tone, mel_tone;
  logic                 samp_tick;
  logic [SAMPLE_W-1:0]  word;
  logic [1:0]           cs_q;
  logic                 cs_load;

  note_tone_bank #(.HALF_WRAP(HALF_WRAP), .CNT_W(CNT_W)) u_tones (
    .clk_i(clk_i), .rst_ni(rst_ni), .tone_o(tones)
  );

  song_sequencer #(.BEAT_CYCLES(BEAT_CYCLES), .GAP_CYCLES(GAP_CYCLES)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(melody_en_i),
    .note_o(seq_note), .sound_o(seq_sound), .gap_o(seq_gap), .idx_o(seq_idx)
  );

  assign tone_pad = 8'(tones);
  assign mel_tone = seq_sound & tone_pad[seq_note];

  // lowest index wins
  always_comb begin
    man_tone = 1'b0;
    for (int i = NUM_NOTES - 1; i >= 0; i--)
      if (note_sw_i[i]) man_tone = tones[i];
  end

  assign tone_o = melody_en_i ? mel_tone : man_tone;

  sample_shifter #(.SAMPLE_WRAP(SAMPLE_WRAP), .SAMPLE_W(SAMPLE_W)) u_samp (
    .clk_i(clk_i), .rst_ni(rst_ni), .tone_i(tone_o), .tick_o(samp_tick), .word_o(word)
  );

  assign cs_load = cs_q[0] && !cs_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= '0;
      music_o <= '0;
    end else begin
      cs_q <= {cs_q[0], cs_i};
      if (cs_load) music_o <= word;
    end
  end
endmodule

// File: rtl/melody_player_chk.sv
module melody_player_chk
  import melody_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        melody_en_i,
  input logic [NUM_NOTES-1:0]        note_sw_i,
  input logic                        tone_o,
  input logic                        cs_load,
  input logic                        seq_gap,
  input logic                        samp_tick,
  input logic [$clog2(SONG_LEN)-1:0] seq_idx,
  input logic [SAMPLE_W-1:0]         word,
  input logic [SAMPLE_W-1:0]         music_o
);
  // R10
  music_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_load |=> $stable(music_o));
  // R10
  music_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_load |=> music_o == $past(word));
  // R9
  word_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_tick |=> (word[SAMPLE_W-1:1] == $past(word[SAMPLE_W-2:0])) && (word[0] == $past(tone_o)));
  // R9
  word_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !samp_tick |=> $stable(word));
  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(melody_en_i) |-> seq_idx == '0);
  // R5
  gap_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (melody_en_i && seq_gap) |-> !tone_o);
  // R3
  idle_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!melody_en_i && note_sw_i == '0) |-> !tone_o);
endmodule

bind melody_player melody_player_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .melody_en_i(melody_en_i), .note_sw_i(note_sw_i),
  .tone_o(tone_o), .cs_load(cs_load), .seq_gap(seq_gap), .samp_tick(samp_tick),
  .seq_idx(seq_idx), .word(word), .music_o(music_o)
);

// File: tb/melody_player_tb.sv
`timescale 1ns/1ps
module melody_player_tb;
  localparam int unsigned WR [7] = '{6, 7, 8, 9, 10, 11, 12};
  localparam int S  = 2;
  localparam int SW = 12;
  localparam int B  = 20;
  localparam int G  = 4;
  localparam int NE = 14;
  localparam int SN [NE] = '{0, 0, 1, 0, 3, 2, 0, 0, 0, 1, 0, 4, 3, 0};
  localparam int SR [NE] = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1};
  localparam int SD [NE] = '{1, 1, 2, 2, 2, 4, 2, 1, 1, 2, 2, 2, 4, 2};

  logic clk = 0, rst_ni = 0, en = 0, cs = 0;
  logic [6:0] sw = '0;
  logic tone_o;
  logic [SW-1:0] music_o;

  int total = 0, bad = 0;
  int unsigned e = 0, seq_n = 0;
  logic [SW-1:0] exp_word = '0, exp_music = '0;
  bit cq1 = 0, cq2 = 0;
  string tag_ovr = "";

  always #2 clk = ~clk;

  melody_player #(.HALF_WRAP(WR), .CNT_W(8), .SAMPLE_WRAP(S), .SAMPLE_W(SW),
                  .BEAT_CYCLES(B), .GAP_CYCLES(G)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .note_sw_i(sw), .melody_en_i(en), .cs_i(cs),
    .tone_o(tone_o), .music_o(music_o));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h edge=%0d", tag, act, exp, e);
    end
  endtask

  function automatic bit tone_at(int i, int unsigned k);
    if (k == 0) return 1'b0;
    return ((k - 1) / (WR[i] + 1)) % 2 == 0;
  endfunction

  function automatic bit manual_at(logic [6:0] s, int unsigned k);
    for (int i = 0; i < 7; i++) if (s[i]) return tone_at(i, k);
    return 1'b0;
  endfunction

  // kind: 0 sounding, 1 gap, 2 rest; note in low bits
  function automatic int mel_pos(int unsigned n);
    int unsigned tot = 0, p;
    for (int i = 0; i < NE; i++) tot += SD[i] * B + G;
    p = n % tot;
    for (int i = 0; i < NE; i++) begin
      if (p < SD[i] * B) return (SR[i] != 0) ? 16 : SN[i];
      p -= SD[i] * B;
      if (p < G) return 8;
      p -= G;
    end
    return 8;
  endfunction

  function automatic bit exp_tone(bit m, logic [6:0] s, int unsigned n, int unsigned k);
    int pos;
    if (!m) return manual_at(s, k);
    pos = mel_pos(n);
    if (pos >= 8) return 1'b0;
    return tone_at(pos, k);
  endfunction

  task automatic step();
    bit pre;
    string tag;
    int pos;
    pre = exp_tone(en, sw, seq_n, e);
    @(posedge clk);
    @(negedge clk);
    if (cq1 && !cq2) exp_music = exp_word;
    if (e % (2 * (S + 1)) == 0) exp_word = {exp_word[SW-2:0], pre};
    cq2 = cq1;
    cq1 = cs;
    e++;
    seq_n = en ? seq_n + 1 : 0;
    if (tag_ovr != "") tag = tag_ovr;
    else if (!en) tag = "R3";
    else begin
      pos = mel_pos(seq_n);
      tag = (pos == 8) ? "R5" : (pos == 16) ? "R6" : "R4";
    end
    chk(tag, 32'(tone_o), 32'(exp_tone(en, sw, seq_n, e)));
    chk("R9,R10", 32'(music_o), 32'(exp_music));
  endtask

  task automatic run(int n, bit rnd_cs);
    for (int i = 0; i < n; i++) begin
      if (rnd_cs) cs = ($urandom % 4) == 0;
      step();
    end
  endtask

  initial begin
    #600000;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    sw = 7'h7f;
    repeat (3) @(negedge clk);
    chk("R1", 32'(tone_o), 0);
    chk("R1", 32'(music_o), 0);
    rst_ni = 1;
    // R2: single note period
    sw = 7'b0000001; tag_ovr = "R2"; run(40, 1'b1);
    sw = 7'b1000000; run(40, 1'b1);
    tag_ovr = "";
    // R3: nothing on, then priority
    sw = '0; run(20, 1'b1);
    sw = 7'b1010100; run(30, 1'b1);
    for (int k = 0; k < 25; k++) begin
      sw = 7'($urandom);
      run(10 + $urandom % 40, 1'b1);
    end
    // R7: restart from entry 0 and loop twice
    en = 1; tag_ovr = "R7"; run(30, 1'b1);
    tag_ovr = ""; run(1400, 1'b1);
    // R8: drop enable, manual selection at once
    sw = 7'b0000100; en = 0; #0.5;
    chk("R8", 32'(tone_o), 32'(manual_at(sw, e)));
    run(20, 1'b1);
    // R7: mid-song re-entry restarts
    en = 1; run(100, 1'b1);
    en = 0; run(3, 1'b1);
    en = 1; tag_ovr = "R7"; run(25, 1'b1);
    tag_ovr = "";
    for (int k = 0; k < 12; k++) begin
      en = $urandom % 2;
      sw = 7'($urandom);
      run(20 + $urandom % 150, 1'b1);
    end
    // R10: long hold with strobe idle, then one strobe
    cs = 0; run(50, 1'b0);
    cs = 1; run(4, 1'b0);
    cs = 0; run(10, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule